// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for each of the two ALU operands of a five-stage in-order integer pipeline, where the operand value should come from. The source register numbers of the instruction sitting in the decode/execute register are compared against the destination register numbers of the two older instructions still in flight. One older instruction sits in the execute/memory register and the other in the memory/writeback register. When an older instruction is going to write a register that the current instruction reads, its result is routed straight to the ALU input. The register file is not used in that case, because it has not yet been updated.

The decision is purely combinational and is made separately for operand A and operand B. Register zero is never forwarded, because it always reads as zero. A stage whose instruction does not write a register never forwards, even if its destination field happens to match. When both older stages target the same register, the newer one (execute/memory) wins, so a chain of dependent updates to one register always sees the latest value. For test and integration convenience the top also contains the two operand multiplexers that apply the selects.

Top module: `fwd_unit`

## Requirements
- R1: Each select uses the encoding 2'b00 for the register-file value, 2'b10 for the execute/memory result and 2'b01 for the memory/writeback result. The value 2'b11 never appears, and with all inputs zero both selects are 2'b00.
- R2: `sel_a` is 2'b10 whenever `exm_we` is 1, `exm_rd` is nonzero and `exm_rd` equals `src_a`.
- R3: `sel_b` is 2'b10 whenever `exm_we` is 1, `exm_rd` is nonzero and `exm_rd` equals `src_b`.
- R4: A select is 2'b01 when `mwb_we` is 1, `mwb_rd` is nonzero and `mwb_rd` equals that operand's source register, and the execute/memory condition for that operand does not hold.
- R5: A source register number of zero always gives select 2'b00, whatever the producer stages hold.
- R6: When both producer stages qualify for the same operand, the select is 2'b10 (the newer execute/memory result).
- R7: A producer stage whose write enable is 0 never causes forwarding, even when its destination equals the source register.
- R8: The select for operand A depends only on `src_a` and the producer fields, and the select for operand B depends only on `src_b` and the producer fields. Different forwarding outcomes for A and B can therefore occur in the same cycle.
- R9: `opnd_a` and `opnd_b` equal `rf_a`/`rf_b`, `exm_data` or `mwb_data` according to their select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 5 | First source register number in decode/execute |
| src_b | input | 5 | Second source register number in decode/execute |
| exm_rd | input | 5 | Destination register number in execute/memory |
| exm_we | input | 1 | Register-write enable of the execute/memory instruction |
| mwb_rd | input | 5 | Destination register number in memory/writeback |
| mwb_we | input | 1 | Register-write enable of the memory/writeback instruction |
| rf_a | input | 32 | Register-file value read for operand A |
| rf_b | input | 32 | Register-file value read for operand B |
| exm_data | input | 32 | Result held in execute/memory |
| mwb_data | input | 32 | Result held in memory/writeback |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | 32 | Selected operand A value |
| opnd_b | output | 32 | Selected operand B value |

## Verification
Every result of this block is due in the same cycle as its stimulus, since no register lies between the inputs and the outputs. The bench applies each new input set just after a rising edge and samples all four outputs at the following falling edge. That leaves half a period for the logic to settle and keeps any sample away from the instant the inputs change. A sweep over every combination of a four-register subset, both write enables and all source registers, followed by random full-width register numbers, covers the zero, priority and disabled-write cases against an arithmetic model.

// File: rtl/fwd_pkg.sv
// Package: shared select encoding for the operand forwarding unit.
// Assumes: the encoding is fixed and visible to the operand mux and to the
// surrounding pipeline; 2'b11 is unused.
package fwd_pkg;
    typedef enum logic [1:0] {
        FWD_FROM_RF  = 2'b00,
        FWD_FROM_WB  = 2'b01,
        FWD_FROM_EXM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
// Module: fwd_hit
// Detects whether one producer stage must forward to one source operand.
// Assumes: register 0 is hard-wired to zero, so a zero destination never
// counts as a producer.
module fwd_hit #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] prod_rd,
    input  logic              prod_we,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Qualify the register-number match with the write enable and the zero rule.
    always_comb begin
        hit = prod_we && (prod_rd != ZERO_REG) && (prod_rd == src);
    end

    // Guard: a producer that does not write never hits, and no hit on register zero.
    always_comb begin
        // R7
        no_write_no_hit_chk: assert (prod_we || !hit);
        // R5
        zero_src_no_hit_chk: assert ((src != ZERO_REG) || !hit);
    end
endmodule

// File: rtl/fwd_pick.sv
// Module: fwd_pick
// Chooses the source of one ALU operand from the two producer stages.
// Assumes: execute/memory holds the newer instruction and takes priority
// over memory/writeback.
module fwd_pick
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] exm_rd,
    input  logic              exm_we,
    input  logic [REG_AW-1:0] mwb_rd,
    input  logic              mwb_we,
    output fwd_sel_e          sel
);
    logic exm_hit;
    logic mwb_hit;

    fwd_hit #(.REG_AW(REG_AW)) u_exm_hit (
        .src(src), .prod_rd(exm_rd), .prod_we(exm_we), .hit(exm_hit)
    );

    fwd_hit #(.REG_AW(REG_AW)) u_mwb_hit (
        .src(src), .prod_rd(mwb_rd), .prod_we(mwb_we), .hit(mwb_hit)
    );

    // Priority select: newest producer first, then the older one, else register file.
    always_comb begin
        if (exm_hit)
            sel = FWD_FROM_EXM;
        else if (mwb_hit)
            sel = FWD_FROM_WB;
        else
            sel = FWD_FROM_RF;
    end

    // Guard: encoding legality, priority and zero-register behaviour of the select.
    always_comb begin
        // R1
        legal_sel_chk: assert (sel != 2'b11);
        // R6
        newer_wins_chk: assert (!(exm_hit && mwb_hit) || (sel == FWD_FROM_EXM));
        // R5
        zero_src_rf_chk: assert ((src != '0) || (sel == FWD_FROM_RF));
        // R7
        idle_producers_chk: assert (exm_we || mwb_we || (sel == FWD_FROM_RF));
    end
endmodule

// File: rtl/fwd_opmux.sv
// Module: fwd_opmux
// Applies a forwarding select to produce one ALU operand value.
// Assumes: the select follows the fwd_pkg encoding; the unused code falls
// back to the register-file value.
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] exm_val,
    input  logic [DATA_W-1:0] mwb_val,
    output logic [DATA_W-1:0] opnd
);
    // Three-way operand selection.
    always_comb begin
        unique case (sel)
            FWD_FROM_EXM: opnd = exm_val;
            FWD_FROM_WB:  opnd = mwb_val;
            default:      opnd = rf_val;
        endcase
    end

    // Guard: the operand tracks the chosen source.
    always_comb begin
        // R9
        exm_path_chk: assert ((sel != FWD_FROM_EXM) || (opnd == exm_val));
        // R9
        wb_path_chk: assert ((sel != FWD_FROM_WB) || (opnd == mwb_val));
    end
endmodule

// File: rtl/fwd_unit.sv
// Module: fwd_unit (top)
// Operand forwarding selector for a five-stage in-order pipeline, with the
// two operand multiplexers attached. Each operand is decided independently.
// Assumes: inputs come straight from the pipeline registers; the block is
// combinational and has no clock or reset.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] src_a,
    input  logic [REG_AW-1:0] src_b,
    input  logic [REG_AW-1:0] exm_rd,
    input  logic              exm_we,
    input  logic [REG_AW-1:0] mwb_rd,
    input  logic              mwb_we,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] exm_data,
    input  logic [DATA_W-1:0] mwb_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NUM_OPS = 2;

    logic [REG_AW-1:0] src_v  [NUM_OPS];
    logic [DATA_W-1:0] rf_v   [NUM_OPS];
    logic [DATA_W-1:0] opnd_v [NUM_OPS];
    fwd_sel_e          sel_v  [NUM_OPS];

    // Gather per-operand inputs into arrays.
    always_comb begin
        src_v[0] = src_a;
        src_v[1] = src_b;
        rf_v[0]  = rf_a;
        rf_v[1]  = rf_b;
    end

    // R8: one independent select and mux per operand.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_pick #(.REG_AW(REG_AW)) u_pick (
            .src(src_v[g]), .exm_rd(exm_rd), .exm_we(exm_we),
            .mwb_rd(mwb_rd), .mwb_we(mwb_we), .sel(sel_v[g])
        );
        fwd_opmux #(.DATA_W(DATA_W)) u_mux (
            .sel(sel_v[g]), .rf_val(rf_v[g]), .exm_val(exm_data),
            .mwb_val(mwb_data), .opnd(opnd_v[g])
        );
    end

    // Drive the top-level outputs from the per-operand results.
    always_comb begin
        sel_a  = sel_v[0];
        sel_b  = sel_v[1];
        opnd_a = opnd_v[0];
        opnd_b = opnd_v[1];
    end
endmodule

// File: tb/tb_fwd_unit.sv
// Bench for fwd_unit: exhaustive sweep over registers 0..3 plus random
// full-range register numbers, checked against an arithmetic model.
module tb_fwd_unit;
    localparam int  REG_AW = 5;
    localparam int  DATA_W = 32;
    localparam time CLK_HALF = 4ns;
    localparam int  WATCHDOG_CYC = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_HALF) clk = ~clk;

    logic [REG_AW-1:0] src_a = '0, src_b = '0, exm_rd = '0, mwb_rd = '0;
    logic              exm_we = 1'b0, mwb_we = 1'b0;
    logic [DATA_W-1:0] rf_a = '0, rf_b = '0, exm_data = '0, mwb_data = '0;
    logic [1:0]        sel_a, sel_b;
    logic [DATA_W-1:0] opnd_a, opnd_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fwd_unit #(.REG_AW(REG_AW), .DATA_W(DATA_W)) dut (
        .src_a(src_a), .src_b(src_b), .exm_rd(exm_rd), .exm_we(exm_we),
        .mwb_rd(mwb_rd), .mwb_we(mwb_we), .rf_a(rf_a), .rf_b(rf_b),
        .exm_data(exm_data), .mwb_data(mwb_data), .sel_a(sel_a),
        .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    function automatic logic [1:0] model_sel(input logic [REG_AW-1:0] s);
        if (exm_we && exm_rd != 0 && exm_rd == s) return 2'b10;
        if (mwb_we && mwb_rd != 0 && mwb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string case_tag(input logic [REG_AW-1:0] s, input string exm_tag);
        bit eh = exm_we && exm_rd != 0 && exm_rd == s;
        bit mh = mwb_we && mwb_rd != 0 && mwb_rd == s;
        if (eh) return mh ? "R6" : exm_tag;
        if (mh) return "R4";
        if (s == 0) return "R5";
        if ((!exm_we && exm_rd == s) || (!mwb_we && mwb_rd == s)) return "R7";
        return "R1";
    endfunction

    task automatic check_val(input string tag, input string what,
                             input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pick(input logic [1:0] s, input logic [DATA_W-1:0] rf);
        return (s == 2'b10) ? exm_data : (s == 2'b01) ? mwb_data : rf;
    endfunction

    task automatic check_all();
        logic [1:0] ea = model_sel(src_a);
        logic [1:0] eb = model_sel(src_b);
        check_val(case_tag(src_a, "R2"), "sel_a", {30'd0, sel_a}, {30'd0, ea});
        check_val(case_tag(src_b, "R3"), "sel_b", {30'd0, sel_b}, {30'd0, eb});
        check_val("R9", "opnd_a", opnd_a, pick(ea, rf_a));
        check_val("R9", "opnd_b", opnd_b, pick(eb, rf_b));
    endtask

    task automatic apply(input logic [REG_AW-1:0] sa, input logic [REG_AW-1:0] sb,
                         input logic [REG_AW-1:0] er, input logic ew,
                         input logic [REG_AW-1:0] mr, input logic mw);
        @(posedge clk);
        src_a = sa; src_b = sb; exm_rd = er; exm_we = ew; mwb_rd = mr; mwb_we = mw;
        rf_a = $urandom; rf_b = $urandom; exm_data = $urandom; mwb_data = $urandom;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all-zero inputs select the register file.
        check_val("R1", "sel_a idle", {30'd0, sel_a}, 32'd0);
        check_val("R1", "sel_b idle", {30'd0, sel_b}, 32'd0);

        // R6: chained update of register 1, both stages write it.
        apply(5'd1, 5'd2, 5'd1, 1'b1, 5'd1, 1'b1);
        check_val("R6", "sel_a chain", {30'd0, sel_a}, 32'd2);
        check_val("R6", "opnd_a chain", opnd_a, exm_data);
        // R8: A from execute/memory and B from memory/writeback together.
        apply(5'd7, 5'd9, 5'd7, 1'b1, 5'd9, 1'b1);
        check_val("R8", "sel_a split", {30'd0, sel_a}, 32'd2);
        check_val("R8", "sel_b split", {30'd0, sel_b}, 32'd1);
        // R7: matching destinations with writes disabled.
        apply(5'd4, 5'd4, 5'd4, 1'b0, 5'd4, 1'b0);
        check_val("R7", "sel_a nowrite", {30'd0, sel_a}, 32'd0);
        check_val("R7", "opnd_b nowrite", opnd_b, rf_b);
        // R5: register zero targeted by both stages.
        apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        check_val("R5", "sel_a zero", {30'd0, sel_a}, 32'd0);
        check_val("R5", "sel_b zero", {30'd0, sel_b}, 32'd0);
        // R4: only memory/writeback matches operand B (register 31).
        apply(5'd3, 5'd31, 5'd3, 1'b0, 5'd31, 1'b1);
        check_val("R4", "sel_b wb", {30'd0, sel_b}, 32'd1);

        // Exhaustive sweep over registers 0..3 and both write enables.
        for (int i = 0; i < 1024; i++) begin
            apply(REG_AW'(i & 3), REG_AW'((i >> 2) & 3), REG_AW'((i >> 4) & 3),
                  1'((i >> 8) & 1), REG_AW'((i >> 6) & 3), 1'((i >> 9) & 1));
            check_all();
        end
        // Random full-range register numbers, biased toward matches.
        for (int i = 0; i < 3000; i++) begin
            logic [REG_AW-1:0] sa = REG_AW'($urandom);
            logic [REG_AW-1:0] sb = ($urandom_range(0, 3) == 0) ? sa : REG_AW'($urandom);
            logic [REG_AW-1:0] er = ($urandom_range(0, 1) == 0) ? sa : REG_AW'($urandom);
            logic [REG_AW-1:0] mr = ($urandom_range(0, 2) == 0) ? er :
                                    ($urandom_range(0, 1) == 0) ? sb : REG_AW'($urandom);
            apply(sa, sb, er, 1'($urandom), mr, 1'($urandom));
            check_all();
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule